// File: doc/BRIEF.md
# One-Shot SAR Offset Trim Controller

This controller trims the DC offset of a differential filter once, after power-up. It drives a segmented current DAC that either pushes current into the filter input or pulls current out of it. Two comparators report whether each filter output sits above the common-mode level. From them the block picks a direction and then runs a nine-bit successive-approximation search. When the search ends, a latch freezes the code until the next reset.

The nine-bit trim code is split into a five-bit upper segment and a four-bit lower segment. The upper segment is sent out as a 31-line thermometer code and the lower segment as plain binary, so full scale is 511 LSB steps. The sequence has eleven steps: one setup step, nine decision steps and one closing step. Each step lasts `STEP_LEN` clock cycles, which covers the two-flop synchronizer on the asynchronous comparator inputs and the DAC settling time.

Top module: `calOffsetTrim`

## Requirements
- R1: While `rstN` is low, `busy`, `done` and `dirExtract` are 0, and `thermo` and `binLsb` are all zeros.
- R2: `busy` goes to 1 at the first clock edge after reset release. It stays at 1 until `done` sets.
- R3: `done` rises at clock edge 11×`STEP_LEN` after reset release, and `busy` falls at that same edge. At edge 11×`STEP_LEN`−1 the block is still busy and not done.
- R4: At the end of the setup step (edge `STEP_LEN`), `dirExtract` is taken from the synchronized comparators. It is 1 (extract) only when both `cmpHiP` and `cmpHiN` are 1 (both outputs above common-mode). It is 0 (inject) when both are 0 and also when they disagree.
- R5: At the end of the setup step, the trial code is 256: the lowest 16 thermometer lines are high and `binLsb` is 0.
- R6: Each of the nine decisions, from bit 8 down to bit 0, clears the trial bit on overshoot and keeps it otherwise. In inject mode, overshoot means either comparator reads 1. In extract mode, it means either comparator reads 0. When the offset comparison is linear in the code, the final code is clamp(min(offP,offN)−1) in extract mode and clamp(−max(offP,offN)) in inject mode, with the clamp limited to 0..511.
- R7: For a code whose upper five bits hold k, the lowest k of the 31 `thermo` lines are high and no others. `binLsb` carries the lower four bits. Code 511 gives all 31 lines high and `binLsb` = 15.
- R8: Once `done` is 1, `dirExtract`, `thermo` and `binLsb` keep their values whatever the comparators do, until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running calibration clock |
| rstN | input | 1 | Active-low reset; its release starts a calibration |
| cmpHiP | input | 1 | Asynchronous comparator: 1 when the positive output is above common-mode |
| cmpHiN | input | 1 | Asynchronous comparator: 1 when the negative output is above common-mode |
| dirExtract | output | 1 | DAC direction: 1 pulls current out, 0 pushes current in |
| thermo | output | 31 | Thermometer code of the upper five trim bits |
| binLsb | output | 4 | Binary lower four trim bits |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Sticky completion latch |

## Verification
The bench models the filter as an offset that the DAC code moves toward zero. It runs several kinds of offset against the search. Large positive and negative offsets drive the code to the clamp at 511 in each direction. Zero and ±1 offsets check the bottom of the range and the rule that a tie settles to inject. Exact powers of two tell a keep decision from a clear decision at the boundary of the MSB trial. Mismatched offsets on the two outputs show that inject is the default when the comparators disagree, and that the tighter of the two comparators limits the result. Random offsets from a fixed seed fill in the rest. After each run the comparators are toggled to confirm that the result stays frozen.

// File: rtl/calPkg.sv
package calPkg;
  // Width of the bit-select carried in the strobe bundle; covers codes up to 32 bits.
  localparam int unsigned SEL_W = 5;

  typedef struct packed {
    logic             latchDir;  // end of setup step: capture direction, load MSB trial
    logic             resolve;   // end of a decision step: judge bitSel
    logic [SEL_W-1:0] bitSel;    // bit under judgement during resolve
  } calStrobeT;
endpackage

// File: rtl/calSync.sv
module calSync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] meta;

  // No reset: the clock runs during reset, so the stages fill with live input values.
  always_ff @(posedge clk) begin
    meta <= din;
    dout <= meta;
  end
endmodule

// File: rtl/calCtrl.sv
module calCtrl
  import calPkg::*;
#(
  parameter int unsigned NBITS    = 9,
  parameter int unsigned STEP_LEN = 4
) (
  input  logic      clk,
  input  logic      rstN,
  output calStrobeT strobe,
  output logic      busy,
  output logic      done
);
  localparam int unsigned LAST_STEP = NBITS + 1;
  localparam int unsigned STEP_W    = $clog2(LAST_STEP + 1);
  localparam int unsigned DIV_W     = (STEP_LEN > 1) ? $clog2(STEP_LEN) : 1;

  logic [DIV_W-1:0]  divCnt;
  logic [STEP_W-1:0] stepIdx;
  logic              tick;

  assign tick = (divCnt == DIV_W'(STEP_LEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      stepIdx <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else if (!done) begin
      busy <= 1'b1;
      if (tick) begin
        divCnt <= '0;
        if (stepIdx == STEP_W'(LAST_STEP)) begin
          done <= 1'b1;
          busy <= 1'b0;
        end else begin
          stepIdx <= stepIdx + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.latchDir = tick && !done && (stepIdx == '0);
    strobe.resolve  = tick && !done && (stepIdx != '0) && (stepIdx <= STEP_W'(NBITS));
    if (strobe.resolve)
      strobe.bitSel = SEL_W'(NBITS) - SEL_W'(stepIdx);
  end

  // R2: once running, busy only drops together with done
  a_r2_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> (busy || done));

  // R1 / R8: the completion latch is sticky and excludes busy
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (done && !busy));

  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.latchDir, strobe.resolve}));

  a_r3_no_strobe_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(strobe.latchDir || strobe.resolve));
endmodule

// File: rtl/calDatapath.sv
module calDatapath
  import calPkg::*;
#(
  parameter int unsigned MSB_BITS = 5,
  parameter int unsigned LSB_BITS = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  calStrobeT                    strobe,
  input  logic                         cmpP,
  input  logic                         cmpN,
  output logic                         dirExtract,
  output logic [(1<<MSB_BITS)-2:0]     thermo,
  output logic [LSB_BITS-1:0]          binLsb
);
  localparam int unsigned NBITS    = MSB_BITS + LSB_BITS;
  localparam int unsigned THERMO_W = (1 << MSB_BITS) - 1;

  logic [NBITS-1:0]    code;
  logic [MSB_BITS-1:0] msbCode;
  logic                overshoot;

  // Overshoot: the correction pushed an output past common-mode in the chosen direction.
  assign overshoot = dirExtract ? !(cmpP && cmpN) : (cmpP || cmpN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirExtract <= 1'b0;
      code       <= '0;
    end else if (strobe.latchDir) begin
      dirExtract <= cmpP && cmpN;
      code       <= NBITS'(1) << (NBITS - 1);
    end else if (strobe.resolve) begin
      if (overshoot)
        code[strobe.bitSel] <= 1'b0;
      if (strobe.bitSel != '0)
        code[strobe.bitSel - 1'b1] <= 1'b1;
    end
  end

  assign msbCode = code[NBITS-1:LSB_BITS];
  assign binLsb  = code[LSB_BITS-1:0];

  for (genvar i = 0; i < THERMO_W; i++) begin : g_thermo
    assign thermo[i] = (msbCode > MSB_BITS'(i));
  end

  // R4: direction only moves at the setup strobe
  a_r4_dir_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchDir |=> $stable(dirExtract));

  // R6: the next lower bit is tried after each decision
  a_r6_next_trial: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.resolve && strobe.bitSel != '0) |=> code[$past(strobe.bitSel) - 1'b1]);

  // R6: bits already decided are never revisited
  a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobe.resolve |=> ((code >> ($past(strobe.bitSel) + 1'b1)) ==
                        ($past(code) >> ($past(strobe.bitSel) + 1'b1))));

  // R7: thermometer lines always form a contiguous run from line 0
  a_r7_thermo_contig: assert property (@(posedge clk) disable iff (!rstN)
    ((({1'b0, thermo}) + 1'b1) & {1'b0, thermo}) == '0);
endmodule

// File: rtl/calOffsetTrim.sv
module calOffsetTrim
  import calPkg::*;
#(
  parameter int unsigned MSB_BITS = 5,
  parameter int unsigned LSB_BITS = 4,
  parameter int unsigned STEP_LEN = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cmpHiP,
  input  logic                     cmpHiN,
  output logic                     dirExtract,
  output logic [(1<<MSB_BITS)-2:0] thermo,
  output logic [LSB_BITS-1:0]      binLsb,
  output logic                     busy,
  output logic                     done
);
  localparam int unsigned NBITS = MSB_BITS + LSB_BITS;

  calStrobeT  strobe;
  logic [1:0] cmpSync;

  calSync #(.WIDTH(2)) i_sync (
    .clk (clk),
    .din ({cmpHiP, cmpHiN}),
    .dout(cmpSync)
  );

  calCtrl #(.NBITS(NBITS), .STEP_LEN(STEP_LEN)) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .busy  (busy),
    .done  (done)
  );

  calDatapath #(.MSB_BITS(MSB_BITS), .LSB_BITS(LSB_BITS)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cmpP      (cmpSync[1]),
    .cmpN      (cmpSync[0]),
    .dirExtract(dirExtract),
    .thermo    (thermo),
    .binLsb    (binLsb)
  );

  // R8: trim outputs are frozen once the latch is set
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    done |=> ($stable(thermo) && $stable(binLsb) && $stable(dirExtract)));

  // R3: done and busy are never high together
  a_r3_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));
endmodule

// File: tb/test_calOffsetTrim.sv
module test_calOffsetTrim;
  localparam int CLK_PERIOD = 10;
  localparam int STEP_LEN   = 4;
  localparam int FRAME      = 11 * STEP_LEN;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmpHiP = 1'b0;
  logic        cmpHiN = 1'b0;
  logic        dirExtract;
  logic [30:0] thermo;
  logic [3:0]  binLsb;
  logic        busy;
  logic        done;
  int          errors = 0;
  int          checks = 0;

  calOffsetTrim #(.MSB_BITS(5), .LSB_BITS(4), .STEP_LEN(STEP_LEN)) i_calOffsetTrim (
    .clk(clk), .rstN(rstN), .cmpHiP(cmpHiP), .cmpHiN(cmpHiN),
    .dirExtract(dirExtract), .thermo(thermo), .binLsb(binLsb),
    .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dutCode();
    return $countones(thermo) * 16 + int'(binLsb);
  endfunction

  function automatic int clampCode(input int v);
    if (v < 0) return 0;
    if (v > 511) return 511;
    return v;
  endfunction

  function automatic int expCode(input int offP, input int offN);
    if (offP > 0 && offN > 0)
      return clampCode(((offP < offN) ? offP : offN) - 1);
    return clampCode(-((offP > offN) ? offP : offN));
  endfunction

  // Behavioural filter plus comparators: the DAC code moves both outputs toward zero.
  task automatic driveCmp(input int offP, input int offN);
    int lvl;
    lvl = dirExtract ? -dutCode() : dutCode();
    cmpHiP = (offP + lvl) > 0;
    cmpHiN = (offN + lvl) > 0;
  endtask

  task automatic runCal(input int offP, input int offN);
    int exp;
    bit expDir;
    logic [30:0] keepT;
    logic [3:0]  keepB;
    logic        keepD;
    exp    = expCode(offP, offN);
    expDir = (offP > 0) && (offN > 0);
    rstN = 1'b0;
    repeat (3) begin
      @(negedge clk);
      driveCmp(offP, offN);
    end
    // R1: reset state
    check(!busy && !done && !dirExtract && thermo == '0 && binLsb == '0,
          "R1 reset state", {busy, done, dirExtract}, 0);
    rstN = 1'b1;
    for (int n = 1; n <= FRAME; n++) begin
      @(negedge clk);
      driveCmp(offP, offN);
      if (n == 1) check(busy == 1'b1, "R2 busy after release", busy, 1);
      if (n == STEP_LEN) begin
        check(dirExtract == expDir, "R4 direction", dirExtract, expDir);
        check(dutCode() == 256 && thermo == 31'h0000FFFF && binLsb == 4'd0,
              "R5 MSB trial", dutCode(), 256);
      end
      if (n == FRAME - 1)
        check(!done && busy, "R3 not done before last edge", done, 0);
    end
    check(done && !busy, "R3 done at last edge", {done, busy}, 2);
    check(dutCode() == exp, "R6 final code", dutCode(), exp);
    check({1'b0, thermo} == ((32'd1 << (exp >> 4)) - 32'd1) && binLsb == exp[3:0],
          "R7 segmentation", int'(thermo), (1 << (exp >> 4)) - 1);
    keepT = thermo;
    keepB = binLsb;
    keepD = dirExtract;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      cmpHiP = $urandom_range(1, 0) == 1;
      cmpHiN = $urandom_range(1, 0) == 1;
    end
    @(negedge clk);
    check(thermo == keepT && binLsb == keepB && dirExtract == keepD && done,
          "R8 frozen after done", dutCode(), int'(keepB) + 16 * $countones(keepT));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int a;
    int b;
    void'($urandom(32'd1357));
    // Directed corners
    runCal(600, 600);     // R6 extract clamp at 511
    runCal(-600, -600);   // R6 inject clamp at 511
    runCal(0, 0);         // R4 tie resolves to inject, code 0
    runCal(1, 1);         // R6 smallest extract -> 0
    runCal(-1, -1);       // R6 smallest inject -> 1
    runCal(256, 256);     // R6 MSB cleared -> 255
    runCal(-256, -256);   // R6 MSB kept -> 256
    runCal(300, -5);      // R4 disagreement -> inject, code 0
    runCal(-300, -200);   // R6 tighter comparator limits -> 200
    runCal(5, 100);       // R6 extract limited by smaller -> 4
    runCal(-512, -511);   // R7 full scale 511
    // Random offsets
    for (int r = 0; r < 20; r++) begin
      a = int'($urandom_range(1400, 0)) - 700;
      b = ($urandom_range(3, 0) == 0) ? int'($urandom_range(1400, 0)) - 700
                                      : a + int'($urandom_range(40, 0)) - 20;
      runCal(a, b);
    end
    summary();
    $finish;
  end
endmodule